// File: doc/BRIEF.md
# Interrupt Vector Address Table

This block keeps one vector address per interrupt channel in a single-port RAM and answers two internal lookup requesters: a fast-interrupt path and a normal-interrupt path. Each requester presents its active channel number and receives that channel's vector one cycle after the RAM port is granted to it. The most recently returned vector is also driven continuously on a dedicated output.

Software reaches the table through a memory-mapped register port with a valid/ready handshake. Table entries sit at byte offset 0x2000 + 4 x channel. The last normal-interrupt vector is at offset 0x18 and the last fast-interrupt vector is at offset 0x1C. Vectors are word aligned, so bits 1:0 are never stored and always read as zero. Bus writes are posted into a one-deep buffer. The lookups always have priority on the RAM port, but they may take at most a bounded run of consecutive slots while a bus access waits. After reset a sequencer writes zero into every entry before any access is allowed.

Top module: `vec_ram_ctrl`

## Requirements
- R1: After reset a clear pass writes zero to all NUM_CH entries, which takes NUM_CH cycles. During the pass bus_ready is low and no lookup is granted. Afterwards every entry reads zero.
- R2: A bus write to table offset 0x2000 + 4*ch, read back later at the same offset, returns the written data with bits 1:0 forced to zero.
- R3: A lookup that is granted (fast_gnt or norm_gnt high at a clock edge) produces a one-cycle valid pulse after that edge, carrying the stored vector of the channel presented, with bits 1:0 zero.
- R4: When both lookups request in the same cycle, the fast lookup is granted and the normal lookup waits.
- R5: Lookups win the RAM port over a pending bus access. While a bus access is pending, at most MAX_RUN (default 2) consecutive lookup grants occur before the bus access is served.
- R6: After a table write is accepted, bus_ready stays low until that write has been committed to the RAM.
- R7: A lookup granted before the pending write commits returns the old vector. A lookup granted after the commit returns the new one.
- R8: A table read holds bus_ready low until its data is returned. bus_rvalid rises one cycle after the read's RAM grant, giving a latency of 2 cycles when idle and MAX_RUN+2 cycles when both lookups are held active.
- R9: A read of offset 0x18 returns the last vector delivered to the normal lookup, and a read of offset 0x1C returns the last vector delivered to the fast lookup. Both reads answer one cycle after acceptance, and both read zero after reset.
- R10: active_vec equals the vector in any cycle with a lookup valid pulse, and otherwise holds the last vector delivered.
- R11: Writes to offsets outside the table are ignored, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_req | input | 1 | Fast-interrupt lookup request |
| fast_ch | input | 8 | Channel of the fast lookup |
| fast_gnt | output | 1 | Fast lookup owns the RAM port this cycle |
| fast_vec_valid | output | 1 | Fast lookup result valid |
| fast_vec | output | 32 | Fast lookup result |
| norm_req | input | 1 | Normal-interrupt lookup request |
| norm_ch | input | 8 | Channel of the normal lookup |
| norm_gnt | output | 1 | Normal lookup owns the RAM port this cycle |
| norm_vec_valid | output | 1 | Normal lookup result valid |
| norm_vec | output | 32 | Normal lookup result |
| active_vec | output | 32 | Most recently returned lookup vector |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Register access accepted at this edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |

## Verification
The hardest case to reach is a posted write racing against a lookup of the same channel, while both lookup requesters keep the RAM busy. The bench holds the fast request high on one channel, issues the write in that same cycle, and then follows the lookup results cycle by cycle. It expects exactly MAX_RUN+1 old vectors, one empty slot where the write commits, and then the new vector. A read issued under the same held load confirms the bounded latency. Random mixes of writes, reads and lookups, checked against a model of the table, cover the remaining behaviour.

// File: rtl/vr_pkg.sv
package vr_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_FAST = 2'd1,
      OWN_NORM = 2'd2,
      OWN_BUS  = 2'd3
   } own_e;
endpackage

// File: rtl/vr_clear_seq.sv
module vr_clear_seq #(
   parameter int NUM_CH = 256,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             busy,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy) begin
         idx <= idx + 1'b1;
         if (idx == LAST) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/vr_vec_store.sv
module vr_vec_store #(
   parameter int DEPTH = 256,
   parameter int DW    = 30,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[idx] <= wdata;
         else    rdata    <= mem[idx];
      end
   end
endmodule

// File: rtl/vr_arbiter.sv
module vr_arbiter
   import vr_pkg::*;
#(
   parameter int MAX_RUN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clearing,
   input  logic fast_req,
   input  logic norm_req,
   input  logic bus_pend,
   output own_e owner
);
   generate
      if (MAX_RUN == 0) begin : g_bus_first
         always_comb begin
            if (clearing)      owner = OWN_NONE;
            else if (bus_pend) owner = OWN_BUS;
            else if (fast_req) owner = OWN_FAST;
            else if (norm_req) owner = OWN_NORM;
            else               owner = OWN_NONE;
         end
      end else begin : g_bounded
         localparam int RUN_W = $clog2(MAX_RUN + 1);
         localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MAX_RUN);
         logic [RUN_W-1:0] run_q;

         always_comb begin
            if (clearing)                          owner = OWN_NONE;
            else if (bus_pend && run_q >= RUN_MAX) owner = OWN_BUS;
            else if (fast_req)                     owner = OWN_FAST;
            else if (norm_req)                     owner = OWN_NORM;
            else if (bus_pend)                     owner = OWN_BUS;
            else                                   owner = OWN_NONE;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_q <= '0;
            else if (clearing || !bus_pend || owner == OWN_BUS)
               run_q <= '0;
            else if ((owner == OWN_FAST || owner == OWN_NORM) && run_q < RUN_MAX)
               run_q <= run_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/vec_ram_ctrl.sv
module vec_ram_ctrl
   import vr_pkg::*;
#(
   parameter int NUM_CH   = 256,
   parameter int VEC_W    = 32,
   parameter int REG_AW   = 14,
   parameter int TBL_BASE = 32'h2000,
   parameter int NORM_OFS = 32'h18,
   parameter int FAST_OFS = 32'h1C,
   parameter int MAX_RUN  = 2,
   localparam int IDX_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_req,
   input  logic [IDX_W-1:0]  fast_ch,
   output logic              fast_gnt,
   output logic              fast_vec_valid,
   output logic [VEC_W-1:0]  fast_vec,
   input  logic              norm_req,
   input  logic [IDX_W-1:0]  norm_ch,
   output logic              norm_gnt,
   output logic              norm_vec_valid,
   output logic [VEC_W-1:0]  norm_vec,
   output logic [VEC_W-1:0]  active_vec,
   input  logic              bus_valid,
   output logic              bus_ready,
   input  logic              bus_write,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [VEC_W-1:0]  bus_wdata,
   output logic              bus_rvalid,
   output logic [VEC_W-1:0]  bus_rdata
);
   localparam int STORE_W = VEC_W - 2;
   localparam int SEL_W   = REG_AW - IDX_W - 2;
   localparam logic [SEL_W-1:0]  TBL_SEL = SEL_W'(TBL_BASE >> (IDX_W + 2));
   localparam logic [REG_AW-1:0] NORM_A  = REG_AW'(NORM_OFS);
   localparam logic [REG_AW-1:0] FAST_A  = REG_AW'(FAST_OFS);

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_depth
         $error("NUM_CH must be a power of two of at least 2");
      end
      if (VEC_W < 4) begin : g_bad_width
         $error("VEC_W too small");
      end
      if (SEL_W < 1) begin : g_bad_aw
         $error("REG_AW too small for the table");
      end
      if ((TBL_BASE % (NUM_CH * 4)) != 0) begin : g_bad_base
         $error("TBL_BASE must be aligned to the table size");
      end
      if (MAX_RUN < 0 || MAX_RUN > 15) begin : g_bad_run
         $error("MAX_RUN out of range");
      end
   endgenerate

   // clear sequencer
   logic             clearing;
   logic [IDX_W-1:0] clr_idx;

   vr_clear_seq #(.NUM_CH(NUM_CH)) u_clear (
      .clk  (clk),
      .rst_n(rst_n),
      .busy (clearing),
      .idx  (clr_idx)
   );

   // bus side state
   logic               wp_valid;
   logic [IDX_W-1:0]   wp_idx;
   logic [STORE_W-1:0] wp_data;
   logic               rd_pend;
   logic [IDX_W-1:0]   rd_idx;
   logic               rd_inflight;
   logic               rsp_valid;
   logic [VEC_W-1:0]   rsp_data;
   logic [STORE_W-1:0] cur_fast;
   logic [STORE_W-1:0] cur_norm;
   logic [STORE_W-1:0] act_q;

   logic             tbl_hit;
   logic [IDX_W-1:0] tbl_idx;
   logic             accept;
   logic             bus_pend;

   assign tbl_hit   = (bus_addr[REG_AW-1:IDX_W+2] == TBL_SEL);
   assign tbl_idx   = bus_addr[IDX_W+1:2];
   assign bus_ready = !clearing && !wp_valid && !rd_pend && !rd_inflight;
   assign accept    = bus_valid && bus_ready;
   assign bus_pend  = wp_valid || rd_pend;

   // arbitration
   own_e owner;
   own_e owner_q;

   vr_arbiter #(.MAX_RUN(MAX_RUN)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .clearing(clearing),
      .fast_req(fast_req),
      .norm_req(norm_req),
      .bus_pend(bus_pend),
      .owner   (owner)
   );

   assign fast_gnt = (owner == OWN_FAST);
   assign norm_gnt = (owner == OWN_NORM);

   // RAM port mux
   logic               ram_en;
   logic               ram_we;
   logic [IDX_W-1:0]   ram_idx;
   logic [STORE_W-1:0] ram_wdata;
   logic [STORE_W-1:0] ram_q;

   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_idx   = '0;
      ram_wdata = '0;
      if (clearing) begin
         ram_en  = 1'b1;
         ram_we  = 1'b1;
         ram_idx = clr_idx;
      end else begin
         case (owner)
            OWN_FAST: begin
               ram_en  = 1'b1;
               ram_idx = fast_ch;
            end
            OWN_NORM: begin
               ram_en  = 1'b1;
               ram_idx = norm_ch;
            end
            OWN_BUS: begin
               ram_en    = 1'b1;
               ram_we    = wp_valid;
               ram_idx   = wp_valid ? wp_idx : rd_idx;
               ram_wdata = wp_data;
            end
            default: ;
         endcase
      end
   end

   vr_vec_store #(.DEPTH(NUM_CH), .DW(STORE_W)) u_store (
      .clk  (clk),
      .en   (ram_en),
      .we   (ram_we),
      .idx  (ram_idx),
      .wdata(ram_wdata),
      .rdata(ram_q)
   );

   // bus request capture and completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_valid    <= 1'b0;
         wp_idx      <= '0;
         wp_data     <= '0;
         rd_pend     <= 1'b0;
         rd_idx      <= '0;
         rd_inflight <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
      end else begin
         rd_inflight <= (owner == OWN_BUS) && !wp_valid;
         rsp_valid   <= 1'b0;
         if (owner == OWN_BUS) begin
            if (wp_valid) wp_valid <= 1'b0;
            else          rd_pend  <= 1'b0;
         end
         if (accept) begin
            if (bus_write) begin
               if (tbl_hit) begin
                  wp_valid <= 1'b1;
                  wp_idx   <= tbl_idx;
                  wp_data  <= bus_wdata[VEC_W-1:2];
               end
            end else if (tbl_hit) begin
               rd_pend <= 1'b1;
               rd_idx  <= tbl_idx;
            end else begin
               rsp_valid <= 1'b1;
               if (bus_addr == NORM_A)      rsp_data <= {cur_norm, 2'b00};
               else if (bus_addr == FAST_A) rsp_data <= {cur_fast, 2'b00};
               else                         rsp_data <= '0;
            end
         end
      end
   end

   // lookup results
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= clearing ? OWN_NONE : owner;
   end

   logic lookup_ret;
   assign lookup_ret     = (owner_q == OWN_FAST) || (owner_q == OWN_NORM);
   assign fast_vec_valid = (owner_q == OWN_FAST);
   assign norm_vec_valid = (owner_q == OWN_NORM);
   assign fast_vec       = {ram_q, 2'b00};
   assign norm_vec       = {ram_q, 2'b00};
   assign active_vec     = lookup_ret ? {ram_q, 2'b00} : {act_q, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_fast <= '0;
         cur_norm <= '0;
         act_q    <= '0;
      end else begin
         if (owner_q == OWN_FAST) cur_fast <= ram_q;
         if (owner_q == OWN_NORM) cur_norm <= ram_q;
         if (lookup_ret)          act_q    <= ram_q;
      end
   end

   assign bus_rvalid = rd_inflight || rsp_valid;
   assign bus_rdata  = rd_inflight ? {ram_q, 2'b00} : rsp_data;
endmodule

// File: rtl/vr_vec_ram_chk.sv
module vr_vec_ram_chk #(
   parameter int NUM_CH   = 256,
   parameter int VEC_W    = 32,
   parameter int REG_AW   = 14,
   parameter int TBL_BASE = 32'h2000,
   parameter int MAX_RUN  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clearing,
   input logic              pending,
   input logic              fast_req,
   input logic              norm_req,
   input logic              fast_gnt,
   input logic              norm_gnt,
   input logic              fast_vec_valid,
   input logic              norm_vec_valid,
   input logic [VEC_W-1:0]  fast_vec,
   input logic [VEC_W-1:0]  norm_vec,
   input logic [VEC_W-1:0]  active_vec,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic              bus_write,
   input logic [REG_AW-1:0] bus_addr,
   input logic              bus_rvalid,
   input logic [VEC_W-1:0]  bus_rdata
);
   localparam int IDX_W = $clog2(NUM_CH);
   localparam int SEL_W = REG_AW - IDX_W - 2;
   localparam logic [SEL_W-1:0] TBL_SEL = SEL_W'(TBL_BASE >> (IDX_W + 2));

   logic tbl_hit;
   assign tbl_hit = (bus_addr[REG_AW-1:IDX_W+2] == TBL_SEL);

   // consecutive lookup grants while a bus access waits
   logic [4:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_cnt <= '0;
      else if (!pending)               run_cnt <= '0;
      else if (fast_gnt || norm_gnt)   run_cnt <= run_cnt + 1'b1;
      else                             run_cnt <= '0;
   end

   AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      clearing |-> (!bus_ready && !fast_gnt && !norm_gnt)); // R1
   AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> (bus_rdata[1:0] == 2'b00)); // R2
   AST_FAST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      fast_gnt |=> fast_vec_valid); // R3
   AST_NORM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      norm_gnt |=> norm_vec_valid); // R3
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fast_vec_valid, norm_vec_valid})); // R3
   AST_FAST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_req && norm_req) |-> !norm_gnt); // R4
   AST_LOOKUP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= 5'(MAX_RUN)); // R5
   AST_WRITE_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_ready && bus_write && tbl_hit) |=> !bus_ready); // R6
   AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_ready && !bus_write && tbl_hit) |=> (!bus_ready && !bus_rvalid)); // R8
   AST_ACTIVE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      fast_vec_valid |-> (active_vec == fast_vec)); // R10
   AST_ACTIVE_NORM: assert property (@(posedge clk) disable iff (!rst_n)
      norm_vec_valid |-> (active_vec == norm_vec)); // R10
   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_vec_valid && !norm_vec_valid && $past(rst_n)) |-> $stable(active_vec)); // R10
endmodule

bind vec_ram_ctrl vr_vec_ram_chk #(
   .NUM_CH  (NUM_CH),
   .VEC_W   (VEC_W),
   .REG_AW  (REG_AW),
   .TBL_BASE(TBL_BASE),
   .MAX_RUN (MAX_RUN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .clearing      (clearing),
   .pending       (bus_pend),
   .fast_req      (fast_req),
   .norm_req      (norm_req),
   .fast_gnt      (fast_gnt),
   .norm_gnt      (norm_gnt),
   .fast_vec_valid(fast_vec_valid),
   .norm_vec_valid(norm_vec_valid),
   .fast_vec      (fast_vec),
   .norm_vec      (norm_vec),
   .active_vec    (active_vec),
   .bus_valid     (bus_valid),
   .bus_ready     (bus_ready),
   .bus_write     (bus_write),
   .bus_addr      (bus_addr),
   .bus_rvalid    (bus_rvalid),
   .bus_rdata     (bus_rdata)
);

// File: tb/vec_ram_ctrl_tb.sv
module vec_ram_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH     = 256;
   localparam int MAX_RUN    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fast_req = 1'b0, norm_req = 1'b0;
   logic [7:0]  fast_ch = '0, norm_ch = '0;
   logic        fast_gnt, norm_gnt, fast_vec_valid, norm_vec_valid;
   logic [31:0] fast_vec, norm_vec, active_vec;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic        bus_ready, bus_rvalid;
   logic [13:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] model [NUM_CH];
   logic [31:0] m_fast = '0, m_norm = '0, m_act = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_ram_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .fast_req(fast_req), .fast_ch(fast_ch), .fast_gnt(fast_gnt),
      .fast_vec_valid(fast_vec_valid), .fast_vec(fast_vec),
      .norm_req(norm_req), .norm_ch(norm_ch), .norm_gnt(norm_gnt),
      .norm_vec_valid(norm_vec_valid), .norm_vec(norm_vec),
      .active_vec(active_vec),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
   );

   function automatic logic [31:0] aligned(input logic [31:0] d);
      return {d[31:2], 2'b00};
   endfunction

   function automatic logic [13:0] tbl_addr(input logic [7:0] ch);
      return 14'h2000 | {4'h0, ch, 2'b00};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      #1;
      while (!bus_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [13:0] a, output logic [31:0] d, output int lat);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1;
      while (!bus_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      bus_valid = 1'b0;
      lat = 1;
      #1;
      while (!bus_rvalid) begin @(negedge clk); #1; lat++; end
      d = bus_rdata;
   endtask

   task automatic look_fast(input logic [7:0] ch);
      @(negedge clk);
      fast_req = 1'b1; fast_ch = ch;
      #1;
      while (!fast_gnt) begin @(negedge clk); #1; end
      @(negedge clk);
      fast_req = 1'b0;
      #1;
      chk(fast_vec_valid && fast_vec == model[ch], "R3 fast lookup", fast_vec, model[ch]);
      chk(active_vec == model[ch], "R10 active after fast", active_vec, model[ch]);
      m_fast = model[ch]; m_act = model[ch];
   endtask

   task automatic look_norm(input logic [7:0] ch);
      @(negedge clk);
      norm_req = 1'b1; norm_ch = ch;
      #1;
      while (!norm_gnt) begin @(negedge clk); #1; end
      @(negedge clk);
      norm_req = 1'b0;
      #1;
      chk(norm_vec_valid && norm_vec == model[ch], "R3 normal lookup", norm_vec, model[ch]);
      chk(active_vec == model[ch], "R10 active after normal", active_vec, model[ch]);
      m_norm = model[ch]; m_act = model[ch];
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      logic [31:0] rd;
      logic [31:0] nv;
      logic [7:0]  c;
      int lat;
      int n;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NUM_CH; i++) model[i] = '0;

      // R1: clear pass after reset
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fast_req = 1'b1; fast_ch = 8'd5;
      n = 0;
      #1;
      while (!bus_ready && n < 1000) begin
         if (fast_gnt) chk(1'b0, "R1 lookup granted during clear", 32'd1, 32'd0);
         @(negedge clk); #1; n++;
      end
      fast_req = 1'b0;
      chk(n == NUM_CH, "R1 clear duration", n, NUM_CH);
      bus_rd(tbl_addr(8'd0), rd, lat);   chk(rd == 0, "R1 entry 0 zero", rd, 0);
      bus_rd(tbl_addr(8'd255), rd, lat); chk(rd == 0, "R1 entry 255 zero", rd, 0);
      chk(lat == 2, "R8 idle read latency", lat, 2);
      bus_rd(14'h0018, rd, lat); chk(rd == 0, "R9 normal reg after reset", rd, 0);
      bus_rd(14'h001C, rd, lat); chk(rd == 0, "R9 fast reg after reset", rd, 0);
      chk(lat == 1, "R9 register read latency", lat, 1);

      // R2: write with low bits set, read back
      bus_wr(tbl_addr(8'd7), 32'hDEAD_BEEF); model[7] = aligned(32'hDEAD_BEEF);
      bus_rd(tbl_addr(8'd7), rd, lat);
      chk(rd == 32'hDEAD_BEEC, "R2 read back low bits zero", rd, 32'hDEAD_BEEC);

      // R11: unmapped write ignored, unmapped read zero
      bus_wr(14'h0100, 32'h1234_5678);
      bus_rd(14'h0100, rd, lat); chk(rd == 0, "R11 unmapped read zero", rd, 0);
      bus_rd(tbl_addr(8'd7), rd, lat);
      chk(rd == model[7], "R11 table untouched by unmapped write", rd, model[7]);

      // R4: simultaneous requests
      bus_wr(tbl_addr(8'd9), 32'h0000_9990); model[9] = 32'h0000_9990;
      bus_wr(tbl_addr(8'd3), 32'h0000_3330); model[3] = 32'h0000_3330;
      @(negedge clk);
      fast_req = 1'b1; fast_ch = 8'd3; norm_req = 1'b1; norm_ch = 8'd9;
      #1;
      chk(fast_gnt && !norm_gnt, "R4 fast wins", {30'd0, fast_gnt, norm_gnt}, 32'd2);
      @(negedge clk);
      fast_req = 1'b0;
      #1;
      chk(fast_vec_valid && fast_vec == model[3], "R4 fast result first", fast_vec, model[3]);
      chk(norm_gnt, "R4 normal served next", norm_gnt, 1);
      @(negedge clk);
      norm_req = 1'b0;
      #1;
      chk(norm_vec_valid && norm_vec == model[9], "R4 normal result", norm_vec, model[9]);
      m_fast = model[3]; m_norm = model[9]; m_act = model[9];
      chk(active_vec == model[9], "R10 active holds last", active_vec, model[9]);

      // R5, R6, R7: posted write under held lookups of the same channel
      c = 8'd3;
      nv = 32'hA5A5_0004;
      @(negedge clk);
      fast_req = 1'b1; fast_ch = c; norm_req = 1'b1; norm_ch = 8'd9;
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = tbl_addr(c); bus_wdata = nv;
      #1;
      chk(bus_ready, "R6 ready before write", bus_ready, 1);
      for (int k = 0; k <= MAX_RUN; k++) begin
         @(negedge clk);
         bus_valid = 1'b0; bus_write = 1'b0;
         #1;
         chk(!bus_ready, "R6 stall while write pending", bus_ready, 0);
         chk(fast_vec_valid && fast_vec == model[c], "R7 old vector before commit", fast_vec, model[c]);
      end
      @(negedge clk); #1;
      chk(!fast_vec_valid, "R5 bus slot after bounded run", fast_vec_valid, 0);
      model[c] = nv;
      @(negedge clk); #1;
      chk(fast_vec_valid && fast_vec == nv, "R7 new vector after commit", fast_vec, nv);
      // R8: read latency with both lookups held
      bus_rd(tbl_addr(c), rd, lat);
      chk(rd == nv, "R8 read under load data", rd, nv);
      chk(lat == MAX_RUN + 2, "R8 read under load latency", lat, MAX_RUN + 2);
      @(negedge clk);
      fast_req = 1'b0; norm_req = 1'b0;
      m_fast = nv;
      @(negedge clk);
      m_act = active_vec;
      bus_rd(14'h001C, rd, lat); chk(rd == nv, "R9 fast reg value", rd, nv);
      bus_rd(14'h0018, rd, lat); chk(rd == model[9], "R9 normal reg value", rd, model[9]);

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         op = $urandom_range(0, 5);
         c = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 7)) : 8'($urandom_range(0, 255));
         case (op)
            0, 1: begin
               nv = $urandom;
               bus_wr(tbl_addr(c), nv);
               model[c] = aligned(nv);
            end
            2: begin
               bus_rd(tbl_addr(c), rd, lat);
               chk(rd == model[c], "R2 random read back", rd, model[c]);
            end
            3: look_fast(c);
            4: look_norm(c);
            default: begin
               if ($urandom_range(0, 1) == 0) begin
                  bus_rd(14'h0018, rd, lat);
                  chk(rd == m_norm, "R9 random normal reg", rd, m_norm);
               end else begin
                  bus_rd(14'h001C, rd, lat);
                  chk(rd == m_fast, "R9 random fast reg", rd, m_fast);
               end
            end
         endcase
      end
      #1;
      chk(active_vec == m_act, "R10 active hold at end", active_vec, m_act);
      finish_run();
   end
endmodule